// File: doc/BRIEF.md
# Strobe/Handshake Byte Read Slave

This block is the slave end of a byte read channel. A master raises a request line to pull one byte. The slave asks an internal byte source for data and watches that source's ready flag. In timed (strobe) mode the slave must put the byte on the bus within a fixed number of cycles after the request. If the source is too slow, the slave raises a stretch line before that window closes. It holds the stretch line until the byte can be driven, then drops it in the same cycle as the byte appears. In four-phase mode the window is not used. The slave raises an acknowledge together with the byte, the master drops its request, and the slave then drops the acknowledge.

Every output comes straight from a registered state. The master can therefore sample stretch, acknowledge, drive-enable and data with no combinational path from its own request. The byte is captured when the source reports ready. It stays on the bus, unchanged, until the master releases the request. The bus data lines read zero whenever the drive-enable is low. After each transfer the slave passes through one release cycle and one idle cycle before it can accept a new request.

Top module: `strobe_read_slave`

## Requirements
- R1: After a synchronous active-high reset, slv_stretch, slv_ack, slv_drive and src_pull are low, and slv_data is zero.
- R2: When mst_req is sampled high in idle, src_pull is high from the next cycle. It stays high until the byte is captured, the transfer is abandoned, or the slave enters the stretch phase, where it also remains high.
- R3: In strobe mode (four_phase = 0), the clock edge that first samples mst_req high counts as edge 0. If src_ready is sampled high at edge d, with 1 <= d <= TA, then slv_drive rises after edge d and slv_data equals src_byte as sampled at edge d. slv_stretch is never raised during that transfer.
- R4: In strobe mode, if src_ready has not been sampled high by edge TA, slv_stretch rises after edge TA. It stays high until src_ready is sampled high. At that edge slv_stretch falls and slv_drive rises in the same cycle. slv_stretch and slv_drive are never high together.
- R5: While mst_req stays high, slv_drive stays high and slv_data holds the captured byte, whatever src_byte does. After the edge that samples mst_req low, slv_drive is low.
- R6: slv_data is all zeros whenever slv_drive is low.
- R7: In four-phase mode (four_phase = 1), slv_stretch is never raised however long the source takes. slv_ack rises together with slv_drive, and both fall after the edge that samples mst_req low. four_phase is changed only while no transfer is in progress.
- R8: A request held high after a transfer does not start a new one. After mst_req is sampled low at edge e, src_pull stays low through edges e+1 and e+2, even if mst_req is high again. It is high after edge e+2 at the earliest.
- R9: If mst_req is sampled low while src_pull is high, all outputs are low after that edge. A later src_ready with mst_req low drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| four_phase | input | 1 | 1 selects acknowledge-based four-phase mode, 0 selects timed strobe mode |
| mst_req | input | 1 | Read request from the master |
| slv_stretch | output | 1 | Stretch line: the byte will come later than the access window |
| slv_ack | output | 1 | Acknowledge in four-phase mode |
| slv_drive | output | 1 | Bus drive-enable, high while the byte is valid |
| slv_data | output | DW | Bus byte, zero when not driven |
| src_ready | input | 1 | Byte source has data available |
| src_byte | input | DW | Byte from the source |
| src_pull | output | 1 | Slave is waiting on the source |

## Verification
Transfers are run with the source's ready arriving one cycle after the request, exactly at the window edge, one cycle past it, and well past it. This separates the fast path from the stretched path at the exact boundary and confirms that stretch and drive swap in the same cycle. The same long delay is repeated in four-phase mode to show that the window no longer matters and that acknowledge follows the data. Further patterns hold the request high across a completed transfer, re-raise it right after release, and abandon it both in the access phase and in the stretch phase. Together these expose any restart without a request low phase, a short release gap, or a byte driven after abandonment.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_WAIT,
        ST_HOLD,
        ST_RELEASE
    } sr_state_e;

    typedef struct packed {
        logic stretch;
        logic drive;
        logic ack;
        logic pull;
    } sr_ctl_t;

    function automatic sr_ctl_t ctl_of(input sr_state_e s, input logic four_ph);
        sr_ctl_t c;
        c         = '0;
        c.stretch = (s == ST_WAIT);
        c.drive   = (s == ST_HOLD);
        c.ack     = (s == ST_HOLD) && four_ph;
        c.pull    = (s == ST_ACCESS) || (s == ST_WAIT);
        return c;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sr_window_ctr.sv
module sr_window_ctr #(
    parameter int unsigned TA = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned   CW    = sr_pkg::cnt_width(TA);
    localparam logic [CW-1:0] LIMIT = CW'(TA);

    logic [CW-1:0] cnt_q;

    // Loaded with 1 outside the access phase, so the first access cycle reads 1.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= CW'(1);
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = run && (cnt_q == LIMIT);

endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
    import sr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      ready,
    input  logic      four_phase,
    input  logic      expired,
    output sr_state_e state,
    output logic      capture
);
    sr_state_e st_q;
    sr_state_e st_d;

    always_comb begin
        st_d    = st_q;
        capture = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req) st_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (!req) begin
                    st_d = ST_RELEASE;
                end else if (ready) begin
                    st_d    = ST_HOLD;
                    capture = 1'b1;
                end else if (!four_phase && expired) begin
                    st_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!req) begin
                    st_d = ST_RELEASE;
                end else if (ready) begin
                    st_d    = ST_HOLD;
                    capture = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!req) st_d = ST_RELEASE;
            end
            ST_RELEASE: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign state = st_q;

endmodule

// File: rtl/sr_data_hold.sv
module sr_data_hold #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          drive,
    input  logic [DW-1:0] src_byte,
    output logic [DW-1:0] bus_byte
);
    logic [DW-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst)          byte_q <= '0;
        else if (capture) byte_q <= src_byte;
    end

    assign bus_byte = drive ? byte_q : '0;

endmodule

// File: rtl/strobe_read_slave.sv
module strobe_read_slave
    import sr_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned TA = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          four_phase,
    input  logic          mst_req,
    output logic          slv_stretch,
    output logic          slv_ack,
    output logic          slv_drive,
    output logic [DW-1:0] slv_data,
    input  logic          src_ready,
    input  logic [DW-1:0] src_byte,
    output logic          src_pull
);
    sr_state_e state;
    sr_ctl_t   ctl;
    logic      capture;
    logic      expired;

    sr_window_ctr #(.TA(TA)) u_window (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_ACCESS),
        .expired (expired)
    );

    sr_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (mst_req),
        .ready      (src_ready),
        .four_phase (four_phase),
        .expired    (expired),
        .state      (state),
        .capture    (capture)
    );

    assign ctl = ctl_of(state, four_phase);

    sr_data_hold #(.DW(DW)) u_data (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .drive    (ctl.drive),
        .src_byte (src_byte),
        .bus_byte (slv_data)
    );

    assign slv_stretch = ctl.stretch;
    assign slv_ack     = ctl.ack;
    assign slv_drive   = ctl.drive;
    assign src_pull    = ctl.pull;

endmodule

// File: rtl/strobe_read_slave_chk.sv
module strobe_read_slave_chk #(
    parameter int unsigned DW = 8,
    parameter int unsigned TA = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          four_phase,
    input logic          mst_req,
    input logic          slv_stretch,
    input logic          slv_ack,
    input logic          slv_drive,
    input logic [DW-1:0] slv_data,
    input logic          src_pull
);
    // Consecutive samples with src_pull high, before the current one.
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst || !src_pull)   run_len <= 0;
        else if (run_len <= TA) run_len <= run_len + 1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !slv_drive && !slv_stretch && !slv_ack && !src_pull);

    a_r3_window_met: assert property (@(posedge clk) disable iff (rst)
        (src_pull && !four_phase && run_len >= TA) |-> slv_stretch);

    a_r4_stretch_drive_excl: assert property (@(posedge clk) disable iff (rst)
        !(slv_stretch && slv_drive));

    a_r4_stretch_hands_over: assert property (@(posedge clk) disable iff (rst)
        ($fell(slv_stretch) && mst_req) |-> slv_drive);

    a_r5_byte_steady: assert property (@(posedge clk) disable iff (rst)
        (slv_drive && mst_req) |=> slv_drive && $stable(slv_data));

    a_r6_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
        !slv_drive |-> (slv_data == '0));

    a_r7_ack_with_byte: assert property (@(posedge clk) disable iff (rst)
        slv_ack |-> slv_drive);

    a_r7_no_stretch_four_phase: assert property (@(posedge clk) disable iff (rst)
        four_phase |-> !slv_stretch);

    a_r8_release_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(slv_drive) |=> !src_pull);

    a_r9_abandon: assert property (@(posedge clk) disable iff (rst)
        (src_pull && !mst_req) |=> !slv_drive && !src_pull && !slv_stretch);

endmodule

bind strobe_read_slave strobe_read_slave_chk #(.DW(DW), .TA(TA)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .four_phase  (four_phase),
    .mst_req     (mst_req),
    .slv_stretch (slv_stretch),
    .slv_ack     (slv_ack),
    .slv_drive   (slv_drive),
    .slv_data    (slv_data),
    .src_pull    (src_pull)
);

// File: tb/test_strobe_read_slave.sv
module test_strobe_read_slave;
    localparam int unsigned DW = 8;
    localparam int unsigned TA = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          four_phase = 1'b0;
    logic          mst_req = 1'b0;
    logic          src_ready = 1'b0;
    logic [DW-1:0] src_byte = '0;
    logic          slv_stretch, slv_ack, slv_drive, src_pull;
    logic [DW-1:0] slv_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    strobe_read_slave #(.DW(DW), .TA(TA)) i_strobe_read_slave (
        .clk(clk), .rst(rst), .four_phase(four_phase), .mst_req(mst_req),
        .slv_stretch(slv_stretch), .slv_ack(slv_ack), .slv_drive(slv_drive),
        .slv_data(slv_data), .src_ready(src_ready), .src_byte(src_byte),
        .src_pull(src_pull)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 fetching, 2 stretched, 3 presenting, 4 releasing
    int            m_phase = 0;
    int            m_elapsed = 0;
    logic [DW-1:0] m_byte = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_elapsed = 0; m_byte = '0;
        end else if (m_phase == 0) begin
            if (mst_req) begin m_phase = 1; m_elapsed = 1; end
        end else if (m_phase == 1 || m_phase == 2) begin
            if (!mst_req) m_phase = 4;
            else if (src_ready) begin m_phase = 3; m_byte = src_byte; end
            else if (m_phase == 1 && !four_phase && m_elapsed >= TA) m_phase = 2;
            else m_elapsed++;
        end else if (m_phase == 3) begin
            if (!mst_req) m_phase = 4;
        end else begin
            m_phase = 0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check("R4 stretch vs model", int'(slv_stretch), int'(m_phase == 2));
            check("R5 drive vs model",   int'(slv_drive),   int'(m_phase == 3));
            check("R6 data vs model",    int'(slv_data),    int'((m_phase == 3) ? m_byte : '0));
            check("R7 ack vs model",     int'(slv_ack),     int'(m_phase == 3 && four_phase));
            check("R2 pull vs model",    int'(src_pull),    int'(m_phase == 1 || m_phase == 2));
        end
    end

    task automatic xfer(input int d, input logic [DW-1:0] v, input logic fp);
        int  n;
        bit  saw;
        string tg;
        tg = fp ? "R7" : ((d <= TA) ? "R3" : "R4");
        four_phase = fp; mst_req = 1'b1; src_ready = 1'b0; n = 0; saw = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (n == 1) check("R2 pull after request", int'(src_pull), 1);
            if (slv_stretch) saw = 1;
            if (slv_drive || n > 60) break;
            if (n >= d) begin src_ready = 1'b1; src_byte = v; end
        end
        check({tg, " latency"}, n, d + 1);
        check({tg, " stretch seen"}, int'(saw), int'(!fp && d > TA));
        check("R4 stretch low with byte", int'(slv_stretch), 0);
        check({tg, " byte"}, int'(slv_data), int'(v));
        check("R7 ack with byte", int'(slv_ack), int'(fp));
        check("R2 pull low after capture", int'(src_pull), 0);
        src_ready = 1'b0; src_byte = ~v;
        repeat (2) @(negedge clk);
        check("R5 drive held", int'(slv_drive), 1);
        check("R5 byte held", int'(slv_data), int'(v));
        mst_req = 1'b0;
        @(negedge clk);
        check("R5 drive off", int'(slv_drive), 0);
        check("R7 ack off", int'(slv_ack), 0);
        check("R6 data zero", int'(slv_data), 0);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 stretch", int'(slv_stretch), 0);
        check("R1 ack", int'(slv_ack), 0);
        check("R1 drive", int'(slv_drive), 0);
        check("R1 data", int'(slv_data), 0);
        check("R1 pull", int'(src_pull), 0);
        rst = 1'b0;
        @(negedge clk);

        xfer(1, 8'hA5, 1'b0);
        xfer(2, 8'h96, 1'b0);
        xfer(TA, 8'h3C, 1'b0);
        xfer(TA + 1, 8'hC3, 1'b0);
        xfer(TA + 5, 8'h5A, 1'b0);
        xfer(TA + 5, 8'h81, 1'b1);
        xfer(1, 8'h7E, 1'b1);

        // R8: request held across a transfer, then re-raised at once
        four_phase = 1'b0; mst_req = 1'b1; src_ready = 1'b1; src_byte = 8'h11;
        repeat (2) @(negedge clk);
        check("R8 first byte", int'(slv_data), 8'h11);
        src_byte = 8'h22;
        repeat (4) @(negedge clk);
        check("R8 no restart drive", int'(slv_drive), 1);
        check("R8 no restart byte", int'(slv_data), 8'h11);
        check("R8 no restart pull", int'(src_pull), 0);
        mst_req = 1'b0;
        @(negedge clk);
        mst_req = 1'b1;
        check("R8 release pull", int'(src_pull), 0);
        @(negedge clk);
        check("R8 idle pull", int'(src_pull), 0);
        @(negedge clk);
        check("R8 restart pull", int'(src_pull), 1);
        @(negedge clk);
        check("R8 second byte", int'(slv_data), 8'h22);
        mst_req = 1'b0; src_ready = 1'b0;
        repeat (2) @(negedge clk);

        // R9: abandon during access
        mst_req = 1'b1;
        repeat (2) @(negedge clk);
        mst_req = 1'b0;
        @(negedge clk);
        check("R9 access abandon pull", int'(src_pull), 0);
        check("R9 access abandon drive", int'(slv_drive), 0);
        @(negedge clk);

        // R9: abandon during stretch
        mst_req = 1'b1;
        repeat (TA + 2) @(negedge clk);
        check("R4 stretch raised", int'(slv_stretch), 1);
        mst_req = 1'b0;
        @(negedge clk);
        check("R9 stretch abandon stretch", int'(slv_stretch), 0);
        check("R9 stretch abandon pull", int'(src_pull), 0);
        src_ready = 1'b1; src_byte = 8'hEE;
        repeat (2) @(negedge clk);
        check("R9 late ready drive", int'(slv_drive), 0);
        check("R9 late ready data", int'(slv_data), 0);
        src_ready = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule